// File: doc/BRIEF.md
# Pairwise Integer Vector Execution Unit

This unit carries out pairwise integer operations on two 128-bit vector operands: wrapping add, signed and unsigned maximum, and signed and unsigned minimum. An execute stage presents a 32-bit instruction word together with the values of the two source registers and a request strobe. The unit decodes the element size, the vector length, the signedness and the operation from the instruction word, and it checks whether that combination is a legal encoding.

The two sources are joined with the second source above the first. Each pair of neighbouring elements collapses into a single result element, so the pairs taken from the first source land in the low result lanes and the pairs taken from the second source land in the high lanes. In the half-width (64-bit vector) form only the low half of each source is used, and the upper half of the result is cleared. The result, an undefined-encoding flag and a valid strobe are all registered and appear one clock after the request.

Top module: `pw_simd_unit`

## Requirements
- R1: Opcode field value 0x17 (instruction bits 15:11) with U=0 (bit 29) adds each element pair, wrapping modulo the element width, for sizes 0, 1 and 2 (bits 23:22 give 8, 16 and 32-bit elements).
- R2: Opcode 0x14 returns the larger element of each pair, compared as signed when U=0 and as unsigned when U=1.
- R3: Opcode 0x15 returns the smaller element of each pair, compared as signed when U=0 and as unsigned when U=1.
- R4: With Q=1 (bit 30), result lanes 0 to N/2-1 come from the pairs of the first source in ascending order, and lanes N/2 to N-1 come from the pairs of the second source, where N is the lane count.
- R5: With Q=0, only bits 63:0 of each source take part. The first source fills the low half of the 64-bit result and the second source fills the high half. Result bits 127:64 are zero.
- R6: Size 3 add with Q=1 gives lane 0 (bits 63:0) as the sum of the two 64-bit elements of the first source, and lane 1 as the sum of the two elements of the second source.
- R7: The undefined flag is raised in each of these cases: size 3 with Q=0; size 3 with max or min; opcode 0x17 with U=1; and any opcode other than 0x14, 0x15 or 0x17.
- R8: For an undefined encoding the result is all zeros and the valid strobe is still pulsed.
- R9: The valid strobe is high exactly in the cycle after each request cycle. Without a request, the result and the flag keep their values.
- R10: While reset is applied, and after it, the result, the flag and the valid strobe are zero until the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe for one operation |
| req_insn | input | 32 | Instruction word |
| req_src_a | input | 128 | First source vector |
| req_src_b | input | 128 | Second source vector |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_undef | output | 1 | Encoding is not allocated |
| rsp_result | output | 128 | Destination vector |

## Verification
The hardest case to reach is the placement of lanes at the join between the two sources. Random data seldom shows that a second-source pair has been moved into a first-source lane, or that a high-half element has leaked in the 64-bit form. The stimulus therefore gives every element of each source a distinct value, fills the unused upper halves with nonzero values in the Q=0 cases, and compares each lane with a reference model that handles the two sources separately rather than as a single joined vector. Signed comparisons are driven with values on both sides of the sign boundary, so that the signed and unsigned answers differ.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int VEC_W    = 128;
    localparam int INSN_W   = 32;
    localparam int N_SIZES  = 4;
    localparam int ELEM_MIN = 8;

    localparam logic [4:0] OPC_MAX = 5'h14;
    localparam logic [4:0] OPC_MIN = 5'h15;
    localparam logic [4:0] OPC_ADD = 5'h17;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_MAX = 2'd1,
        OP_MIN = 2'd2,
        OP_BAD = 2'd3
    } pw_op_e;

    typedef struct packed {
        logic       wide;
        logic       uns;
        logic [1:0] size;
        pw_op_e     op;
        logic       undef;
    } pw_dec_t;
endpackage

// File: rtl/pw_decode.sv
module pw_decode
    import pw_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output pw_dec_t           dec
);
    logic [4:0] opc;
    logic       size_top;
    logic       unused_insn_bits;

    assign opc              = insn[15:11];
    assign size_top         = (insn[23:22] == 2'd3);
    assign unused_insn_bits = ^{insn[31], insn[28:24], insn[21:16], insn[10:0]};

    always_comb begin
        dec.wide  = insn[30];
        dec.uns   = insn[29];
        dec.size  = insn[23:22];
        dec.op    = OP_BAD;
        dec.undef = 1'b1;
        unique case (opc)
            OPC_ADD: begin
                dec.op    = OP_ADD;
                dec.undef = insn[29];
            end
            OPC_MAX: begin
                dec.op    = OP_MAX;
                dec.undef = size_top;
            end
            OPC_MIN: begin
                dec.op    = OP_MIN;
                dec.undef = size_top;
            end
            default: begin
                dec.op    = OP_BAD;
                dec.undef = 1'b1;
            end
        endcase
        if (size_top && !insn[30]) begin
            dec.undef = 1'b1;
        end
    end
endmodule

// File: rtl/pw_lane_unit.sv
module pw_lane_unit
    import pw_pkg::*;
#(
    parameter int EW = 8,
    parameter int VW = 128
) (
    input  logic [2*VW-1:0] cat,
    input  pw_op_e          op,
    input  logic            uns,
    output logic [VW-1:0]   res
);
    localparam int LANES = VW / EW;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [EW-1:0] x_lo;
        logic [EW-1:0] x_hi;
        logic [EW-1:0] sum;
        logic          lo_less;

        assign x_lo    = cat[(2*i)*EW   +: EW];
        assign x_hi    = cat[(2*i+1)*EW +: EW];
        assign sum     = x_lo + x_hi;
        assign lo_less = uns ? (x_lo < x_hi) : ($signed(x_lo) < $signed(x_hi));

        always_comb begin
            unique case (op)
                OP_ADD:  res[i*EW +: EW] = sum;
                OP_MAX:  res[i*EW +: EW] = lo_less ? x_hi : x_lo;
                OP_MIN:  res[i*EW +: EW] = lo_less ? x_lo : x_hi;
                default: res[i*EW +: EW] = '0;
            endcase
        end
    end
endmodule

// File: rtl/pw_simd_unit.sv
module pw_simd_unit
    import pw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [INSN_W-1:0] req_insn,
    input  logic [VEC_W-1:0]  req_src_a,
    input  logic [VEC_W-1:0]  req_src_b,
    output logic              rsp_valid,
    output logic              rsp_undef,
    output logic [VEC_W-1:0]  rsp_result
);
    localparam int HALF_W = VEC_W / 2;

    typedef struct packed {
        logic             valid;
        logic             undef;
        logic [VEC_W-1:0] result;
    } state_t;

    state_t          st_d;
    state_t          st_q;
    pw_dec_t         dec;
    logic [2*VEC_W-1:0] cat;
    logic [VEC_W-1:0]   width_res [N_SIZES];
    logic [VEC_W-1:0]   pick;

    pw_decode u_decode (
        .insn (req_insn),
        .dec  (dec)
    );

    assign cat = dec.wide ? {req_src_b, req_src_a}
                          : {{VEC_W{1'b0}}, req_src_b[HALF_W-1:0], req_src_a[HALF_W-1:0]};

    for (genvar g = 0; g < N_SIZES; g++) begin : g_width
        localparam int EW = ELEM_MIN << g;
        pw_lane_unit #(
            .EW (EW),
            .VW (VEC_W)
        ) u_lanes (
            .cat (cat),
            .op  (dec.op),
            .uns (dec.uns),
            .res (width_res[g])
        );
    end

    always_comb begin
        pick = width_res[dec.size];
        if (!dec.wide) begin
            pick[VEC_W-1:HALF_W] = '0;
        end
        st_d       = st_q;
        st_d.valid = req_valid;
        if (req_valid) begin
            st_d.undef  = dec.undef;
            st_d.result = dec.undef ? '0 : pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid  = st_q.valid;
    assign rsp_undef  = st_q.undef;
    assign rsp_result = st_q.result;

    // R9: strobe follows the request by exactly one cycle
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rsp_valid == $past(req_valid)));

    // R9: idle cycles leave the outputs unchanged
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_result) && $stable(rsp_undef)));

    // R8: an undefined encoding never carries data
    p_undef_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_undef |-> (rsp_result == '0));

    // R5: the half-width form clears the upper half of the result
    p_half_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_insn[30]) |=> (rsp_result[VEC_W-1:HALF_W] == '0));

    // R7: 64-bit elements need the full-width form
    p_size3_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_insn[23:22] == 2'd3 && !req_insn[30]) |=> rsp_undef);

    // R7: pairwise add has no unsigned variant
    p_add_unsigned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_insn[15:11] == OPC_ADD && req_insn[29]) |=> rsp_undef);
endmodule

// File: tb/tb_pw_simd_unit.sv
`timescale 1ns/1ps
module tb_pw_simd_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_insn = '0;
    logic [127:0] req_src_a = '0;
    logic [127:0] req_src_b = '0;
    logic         rsp_valid;
    logic         rsp_undef;
    logic [127:0] rsp_result;

    int n_tests = 0;
    int n_fail  = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    pw_simd_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_insn   (req_insn),
        .req_src_a  (req_src_a),
        .req_src_b  (req_src_b),
        .rsp_valid  (rsp_valid),
        .rsp_undef  (rsp_undef),
        .rsp_result (rsp_result)
    );

    function automatic logic [31:0] mk(input logic q, input logic u,
                                       input logic [1:0] sz, input logic [4:0] opc);
        return {1'b0, q, u, 5'b01110, sz, 1'b1, 5'd7, opc, 1'b1, 5'd3, 5'd9};
    endfunction

    function automatic logic [127:0] pat(input logic [63:0] seed);
        logic [63:0] s;
        logic [127:0] r;
        s = seed ^ 64'h9e3779b97f4a7c15;
        for (int k = 0; k < 2; k++) begin
            s = s ^ (s << 13);
            s = s ^ (s >> 7);
            s = s ^ (s << 17);
            r[k*64 +: 64] = s;
        end
        return r;
    endfunction

    // Reference: the two sources are handled separately, lane by lane
    function automatic logic [128:0] ref_model(input logic [31:0] insn,
                                               input logic [127:0] a, input logic [127:0] b);
        logic q, u, bad;
        logic [1:0] sz;
        logic [4:0] opc;
        int ew, nl, j;
        logic [127:0] src, res;
        logic [63:0] mask, x, y, r;
        logic signed [63:0] xs, ys;
        q = insn[30]; u = insn[29]; sz = insn[23:22]; opc = insn[15:11];
        bad = 1'b0;
        if (opc == 5'h17) bad = u;
        else if (opc == 5'h14 || opc == 5'h15) bad = (sz == 2'd3);
        else bad = 1'b1;
        if (sz == 2'd3 && !q) bad = 1'b1;
        if (bad) return {1'b1, 128'h0};
        ew = 8 << sz;
        nl = (q ? 128 : 64) / ew;
        mask = (ew == 64) ? '1 : ((64'd1 << ew) - 64'd1);
        res = '0;
        for (int i = 0; i < nl; i++) begin
            src = (i < nl/2) ? a : b;
            j = (i < nl/2) ? i : i - nl/2;
            x = 64'(src >> (2*j*ew)) & mask;
            y = 64'(src >> ((2*j+1)*ew)) & mask;
            xs = $signed(x << (64-ew)) >>> (64-ew);
            ys = $signed(y << (64-ew)) >>> (64-ew);
            if (opc == 5'h17) r = (x + y) & mask;
            else if (opc == 5'h14) r = (u ? (x > y) : (xs > ys)) ? x : y;
            else r = (u ? (x < y) : (xs < ys)) ? x : y;
            res = res | (128'(r & mask) << (i*ew));
        end
        return {1'b0, res};
    endfunction

    task automatic check(input string tag, input logic [129:0] act, input logic [129:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [31:0] insn,
                          input logic [127:0] a, input logic [127:0] b);
        logic [128:0] e;
        e = ref_model(insn, a, b);
        @(negedge clk);
        req_insn = insn; req_src_a = a; req_src_b = b; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, {rsp_valid, rsp_undef, rsp_result}, {1'b1, e});
    endtask

    task automatic t_reset;
        // R10: outputs are zero out of reset
        check("R10 reset", {rsp_valid, rsp_undef, rsp_result}, '0);
    endtask

    task automatic t_add;
        run_op("R1 add size0", mk(1, 0, 0, 5'h17), {16{8'h80}}, pat(1));
        check("R1 add size0 wrap lane0", {122'h0, rsp_result[7:0]}, '0);
        run_op("R1 add size1", mk(1, 0, 1, 5'h17), pat(2), pat(3));
        run_op("R1 add size2", mk(1, 0, 2, 5'h17), {4{32'hffff_fff0}}, pat(4));
    endtask

    task automatic t_maxmin;
        logic [127:0] a;
        a = {{7{16'h0102}}, 16'h0180};
        run_op("R2 smax8", mk(1, 0, 0, 5'h14), a, pat(5));
        check("R2 smax8 lane0", {122'h0, rsp_result[7:0]}, 130'h01);
        run_op("R2 umax8", mk(1, 1, 0, 5'h14), a, pat(5));
        check("R2 umax8 lane0", {122'h0, rsp_result[7:0]}, 130'h80);
        run_op("R2 smax16", mk(1, 0, 1, 5'h14), pat(6), pat(7));
        run_op("R2 umax32", mk(1, 1, 2, 5'h14), pat(8), pat(9));
        run_op("R3 smin8", mk(1, 0, 0, 5'h15), a, pat(10));
        check("R3 smin8 lane0", {122'h0, rsp_result[7:0]}, 130'h80);
        run_op("R3 umin16", mk(1, 1, 1, 5'h15), pat(11), pat(12));
        run_op("R3 smin32", mk(1, 0, 2, 5'h15), pat(13), pat(14));
    endtask

    task automatic t_order;
        logic [127:0] a, b;
        for (int k = 0; k < 16; k++) begin
            a[k*8 +: 8] = 8'(k);
            b[k*8 +: 8] = 8'(8'h40 + k);
        end
        // R4: lane i of 8-bit add: a pairs give 2k+... in low lanes
        run_op("R4 order add8", mk(1, 0, 0, 5'h17), a, b);
        check("R4 lane7", {122'h0, rsp_result[63:56]}, 130'd29);
        check("R4 lane8", {122'h0, rsp_result[71:64]}, 130'h81);
        run_op("R4 order umax16", mk(1, 1, 1, 5'h14), a, b);
    endtask

    task automatic t_narrow;
        run_op("R5 add8 Q0", mk(0, 0, 0, 5'h17), pat(20), pat(21));
        run_op("R5 smin16 Q0", mk(0, 0, 1, 5'h15), pat(22), pat(23));
        run_op("R5 umax32 Q0", mk(0, 1, 2, 5'h14), pat(24), pat(25));
        check("R5 upper zero", {66'h0, rsp_result[127:64]}, '0);
    endtask

    task automatic t_dword;
        run_op("R6 add64", mk(1, 0, 3, 5'h17),
               {64'd2, 64'd1}, {64'd20, 64'hffff_ffff_ffff_fffe});
        check("R6 lanes", {2'b0, rsp_result}, {2'b0, 64'd18, 64'd3});
    endtask

    task automatic t_undef;
        run_op("R7 size3 Q0", mk(0, 0, 3, 5'h17), pat(30), pat(31));
        run_op("R7 max size3", mk(1, 0, 3, 5'h14), pat(32), pat(33));
        run_op("R7 min size3", mk(1, 1, 3, 5'h15), pat(34), pat(35));
        run_op("R7 add U1", mk(1, 1, 0, 5'h17), pat(36), pat(37));
        run_op("R7 opc 0x16", mk(1, 0, 0, 5'h16), pat(38), pat(39));
        // R8: flag and zero result with strobe pulsed
        check("R8 undef strobe", {rsp_valid, rsp_undef, rsp_result}, {2'b11, 128'h0});
    endtask

    task automatic t_idle;
        logic [128:0] e;
        e = ref_model(mk(1, 0, 1, 5'h17), pat(40), pat(41));
        run_op("R9 op", mk(1, 0, 1, 5'h17), pat(40), pat(41));
        @(negedge clk);
        req_insn = mk(1, 1, 0, 5'h17); req_src_a = pat(42);
        check("R9 idle hold", {rsp_valid, rsp_undef, rsp_result}, {1'b0, e});
        @(negedge clk);
        check("R9 idle hold2", {rsp_valid, rsp_undef, rsp_result}, {1'b0, e});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add();
        t_maxmin();
        t_order();
        t_narrow();
        t_dword();
        t_undef();
        t_idle();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule